// File: doc/BRIEF.md
# SPI Flash Page Program Engine

This block is the device-side command logic of a small serial NOR flash. A host reaches it over a four-wire serial link (chip select, serial clock, data in, data out) and may set the write-enable latch, program part of one 256-byte page, read the status byte and read back the array. All link inputs are brought into the system clock domain. Edges of the serial clock are found there, so both clock polarities that idle low (mode 0) and idle high (mode 3) work without any setting.

A program frame is staged in a page buffer that records which in-page offsets received data. When chip select rises at a legal point, a timed busy period starts. The engine walks the page during that period and ANDs each staged byte into the array, so bits can only fall from 1 to 0. Frames that break the framing rules, lack write enable, or aim at a protected page leave the array untouched. The protect level comes from the surrounding chip on a three-bit input and is shown in the status byte.

Top module: `spi_nor_pgm`

## Requirements
- R1: After reset the status byte is {3'b000, protect level[2:0], write-enable, busy} with write-enable 0 and busy 0, and `miso` is 0 whenever chip select is high.
- R2: A frame holding exactly the single opcode 0x06 sets the write-enable latch (status bit 1).
- R3: A program frame (opcode 0x02, three address bytes MSB first, then data) leaves the array unchanged when the write-enable latch is clear.
- R4: A program stores old contents AND new data, so a programmed bit never goes from 0 back to 1.
- R5: A burst of 256 or fewer data bytes lands at consecutive offsets from the given address, and all other bytes of the array keep their values.
- R6: The in-page offset wraps from 255 to 0 inside the addressed page; when more than 256 data bytes arrive, each offset keeps the last byte sent to it.
- R7: A program is dropped when chip select rises anywhere other than right after the 8th bit of a data byte, including a frame that has no data byte.
- R8: Busy (status bit 0) is 1 from the chip-select rise of an accepted program until PROG_CYCLES clock cycles later. The write-enable latch is 0 before busy falls.
- R9: With protect level k (1..7) the top k eighths of the pages are protected, and a program into a protected page is dropped; level 0 protects nothing.
- R10: While busy is 1, every opcode other than status read (0x05) is ignored; a write-enable sent then does not set the latch.
- R11: Input data is sampled on the rising serial-clock edge and output data changes on the falling edge, MSB first, in both mode 0 and mode 3.
- R12: Opcode 0x03 followed by a 24-bit address returns array bytes from that address in order, with the address incrementing and wrapping at the top of the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| blk_prot | input | 3 | Protect level, shown in status bits 4:2 |
| miso | output | 1 | Serial data to the host |

## Verification
Each link input passes through a two-stage synchronizer, so a serial-clock edge takes effect two to three system cycles after the bench drives it. The output bit is registered one cycle after a falling edge is seen. The bench therefore drives and samples on the falling system edge and holds every serial-clock phase for four cycles, reading `miso` at the end of the low phase, after the output has settled. Array effects of a program appear only after the busy period, so the bench waits PROG_CYCLES plus a margin before it reads back. Status checks made just after a program are placed well inside that period.

// File: rtl/spi_nor_pgm_pkg.sv
package spi_nor_pgm_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;

  function automatic logic [7:0] pack_status(input logic busy, input logic wen,
                                             input logic [2:0] lvl);
    return {3'b000, lvl, wen, busy};
  endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_rise,
  output logic mosi_s
);
  logic [STAGES:0]   sck_sh;
  logic [STAGES:0]   cs_sh;
  logic [STAGES-1:0] mo_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sh <= '0;
      cs_sh  <= '1;
      mo_sh  <= '0;
    end else begin
      sck_sh <= {sck_sh[STAGES-1:0], sck};
      cs_sh  <= {cs_sh[STAGES-1:0], cs_n};
      mo_sh  <= {mo_sh[STAGES-2:0], mosi};
    end
  end

  assign sck_rise = sck_sh[STAGES-1] & ~sck_sh[STAGES];
  assign sck_fall = ~sck_sh[STAGES-1] & sck_sh[STAGES];
  assign cs_act   = ~cs_sh[STAGES-1];
  assign cs_rise  = cs_sh[STAGES-1] & ~cs_sh[STAGES];
  assign mosi_s   = mo_sh[STAGES-1];
endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic [OFF_W-1:0] wa,
  input  logic [7:0]       wd,
  input  logic [OFF_W-1:0] ra,
  output logic [7:0]       rd,
  output logic             rm
);
  localparam int DEPTH = 1 << OFF_W;

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] hit;

  // plain dual-port RAM, no reset, for block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hit <= '0;
      rm  <= 1'b0;
    end else begin
      if (we) hit[wa] <= 1'b1;
      rm <= hit[ra];
    end
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // erased state at configuration time
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/prog_engine.sv
module prog_engine #(
  parameter int AW          = 11,
  parameter int OFF_W       = 8,
  parameter int PROG_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [AW-OFF_W-1:0] page,
  output logic                busy,
  output logic [OFF_W-1:0]    buf_ra,
  input  logic [7:0]          buf_rd,
  input  logic                buf_rm,
  output logic [AW-1:0]       arr_ra,
  input  logic [7:0]          arr_rd,
  output logic                arr_we,
  output logic [AW-1:0]       arr_wa,
  output logic [7:0]          arr_wd
);
  localparam int DEPTH    = 1 << OFF_W;
  localparam int MIN_CYC  = DEPTH + 16;
  localparam int BUSY_CYC = (PROG_CYCLES > MIN_CYC) ? PROG_CYCLES : MIN_CYC;
  localparam int TW       = $clog2(BUSY_CYC + 1);

  logic [TW-1:0]       timer;
  logic [OFF_W:0]      walk;
  logic [AW-OFF_W-1:0] pg;
  logic                p_valid;
  logic [OFF_W-1:0]    p_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      timer   <= '0;
      walk    <= '0;
      pg      <= '0;
      p_valid <= 1'b0;
      p_off   <= '0;
    end else begin
      p_valid <= busy && !walk[OFF_W];
      p_off   <= walk[OFF_W-1:0];
      if (start && !busy) begin
        busy  <= 1'b1;
        timer <= '0;
        walk  <= '0;
        pg    <= page;
      end else if (busy) begin
        if (!walk[OFF_W]) walk <= walk + 1'b1;
        if (timer == TW'(BUSY_CYC - 1)) busy <= 1'b0;
        else timer <= timer + 1'b1;
      end
    end
  end

  // read both memories at the walk offset, merge one cycle later
  assign buf_ra = walk[OFF_W-1:0];
  assign arr_ra = {pg, walk[OFF_W-1:0]};
  assign arr_we = p_valid && buf_rm;
  assign arr_wa = {pg, p_off};
  assign arr_wd = arr_rd & buf_rd;
endmodule

// File: rtl/spi_nor_pgm.sv
module spi_nor_pgm
  import spi_nor_pgm_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int OFF_W       = 8,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [2:0] blk_prot,
  output logic       miso
);
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int NPAGES = 1 << PG_W;
  localparam int EIGHTH = NPAGES / 8;
  localparam logic [2:0] BYTE_DATA = 3'd5;

  logic sck_rise, sck_fall, cs_act, cs_rise, mosi_s;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_rise(cs_rise), .mosi_s(mosi_s)
  );

  logic [6:0]        sh;
  logic [2:0]        bitcnt;
  logic [2:0]        bytecnt;
  logic [7:0]        opcode;
  logic [ADDR_W-1:0] addr;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] rd_ptr;
  logic [7:0]        out_byte;
  logic              rd_pend;
  logic              wel;
  logic              wip;
  logic [2:0]        bp_q;

  logic [7:0]        byte_in;
  logic              byte_done;
  logic [ADDR_W-1:0] addr_full;
  logic [7:0]        status;

  assign byte_in   = {sh, mosi_s};
  assign byte_done = cs_act && sck_rise && (bitcnt == 3'd7);
  assign addr_full = ADDR_W'({addr, byte_in});
  assign status    = pack_status(wip, wel, bp_q);

  // protection window: top bp_q eighths of the pages
  logic [PG_W:0]   prot_span;
  logic [PG_W-1:0] page;
  logic            prot_hit;
  assign page      = addr[ADDR_W-1:OFF_W];
  assign prot_span = (PG_W+1)'(bp_q) * (PG_W+1)'(EIGHTH);
  assign prot_hit  = ({1'b0, page} >= ((PG_W+1)'(NPAGES) - prot_span));

  logic frame_ok_prog, frame_ok_wren, start_pgm;
  assign frame_ok_prog = (opcode == OP_PROG) && (bytecnt == BYTE_DATA) && (bitcnt == 3'd0);
  assign frame_ok_wren = (opcode == OP_WREN) && (bytecnt == 3'd1) && (bitcnt == 3'd0);
  assign start_pgm     = cs_rise && frame_ok_prog && wel && !wip && !prot_hit;

  // frame deserializer
  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bitcnt  <= '0;
      bytecnt <= '0;
    end else if (sck_rise) begin
      bitcnt <= bitcnt + 1'b1;
      if (bitcnt == 3'd7 && bytecnt != BYTE_DATA) bytecnt <= bytecnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      opcode <= '0;
      addr   <= '0;
      off    <= '0;
      bp_q   <= '0;
    end else begin
      bp_q <= blk_prot;
      if (cs_act && sck_rise) sh <= {sh[5:0], mosi_s};
      if (byte_done) begin
        case (bytecnt)
          3'd0:                opcode <= byte_in;
          3'd1, 3'd2, 3'd3:    addr   <= addr_full;
          default: ;
        endcase
      end
      if (byte_done && bytecnt == 3'd3) off <= addr_full[OFF_W-1:0];
      else if (buf_we) off <= off + 1'b1;
    end
  end

  // page buffer staging, blocked while a program runs
  logic             buf_we;
  logic [OFF_W-1:0] eng_buf_ra;
  logic [7:0]       buf_rd;
  logic             buf_rm;
  logic             cs_fall_q;
  logic             cs_act_q;

  assign buf_we = byte_done && (bytecnt >= 3'd4) && (opcode == OP_PROG) && !wip;

  always_ff @(posedge clk) begin
    if (rst) cs_act_q <= 1'b0;
    else     cs_act_q <= cs_act;
  end
  assign cs_fall_q = cs_act && !cs_act_q && !wip;

  page_buffer #(.OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst(rst), .clr(cs_fall_q), .we(buf_we), .wa(off), .wd(byte_in),
    .ra(eng_buf_ra), .rd(buf_rd), .rm(buf_rm)
  );

  // array and commit engine
  logic [ADDR_W-1:0] eng_arr_ra, arr_ra, arr_wa, req_addr;
  logic [7:0]        arr_rd, arr_wd;
  logic              arr_we, rd_issue;

  assign rd_issue = byte_done && (bytecnt >= 3'd3) && (opcode == OP_READ) && !wip;
  assign req_addr = (bytecnt == 3'd3) ? addr_full : rd_ptr;
  assign arr_ra   = wip ? eng_arr_ra : req_addr;

  prog_engine #(.AW(ADDR_W), .OFF_W(OFF_W), .PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .start(start_pgm), .page(page), .busy(wip),
    .buf_ra(eng_buf_ra), .buf_rd(buf_rd), .buf_rm(buf_rm),
    .arr_ra(eng_arr_ra), .arr_rd(arr_rd), .arr_we(arr_we),
    .arr_wa(arr_wa), .arr_wd(arr_wd)
  );

  flash_array #(.AW(ADDR_W)) u_arr (
    .clk(clk), .ra(arr_ra), .rd(arr_rd), .we(arr_we), .wa(arr_wa), .wd(arr_wd)
  );

  // write-enable latch
  always_ff @(posedge clk) begin
    if (rst)                                wel <= 1'b0;
    else if (start_pgm)                     wel <= 1'b0;
    else if (cs_rise && frame_ok_wren && !wip) wel <= 1'b1;
  end

  // output path: byte loaded on rising side, bits shifted out on falls
  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte <= '0;
      miso     <= 1'b0;
      rd_pend  <= 1'b0;
      rd_ptr   <= '0;
    end else begin
      rd_pend <= rd_issue;
      if (rd_issue) rd_ptr <= req_addr + ADDR_W'(1);
      if (!cs_act)
        out_byte <= '0;
      else if (rd_pend)
        out_byte <= arr_rd;
      else if (byte_done && ((bytecnt == 3'd0 && byte_in == OP_RDSR) ||
                             (bytecnt != 3'd0 && opcode == OP_RDSR)))
        out_byte <= status;
      if (!cs_act)       miso <= 1'b0;
      else if (sck_fall) miso <= out_byte[~bitcnt];
    end
  end
endmodule

// File: rtl/spi_nor_pgm_chk.sv
module spi_nor_pgm_chk (
  input logic clk,
  input logic rst,
  input logic cs_act,
  input logic cs_rise,
  input logic sck_fall,
  input logic wip,
  input logic wel,
  input logic prot_hit,
  input logic start_pgm,
  input logic arr_we,
  input logic miso
);
  // R8
  wip_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(start_pgm));
  // R7
  wip_cs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(cs_rise));
  // R3
  wip_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(wel));
  // R9
  wip_unprot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> !$past(prot_hit));
  // R8
  wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !wel);
  // R10
  wel_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> !$past(wip));
  // R8
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> wip);
  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);
  // R11
  miso_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_act && $past(cs_act) && !$stable(miso)) |-> $past(sck_fall));
endmodule

bind spi_nor_pgm spi_nor_pgm_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .cs_rise(cs_rise), .sck_fall(sck_fall),
  .wip(wip), .wel(wel), .prot_hit(prot_hit), .start_pgm(start_pgm),
  .arr_we(arr_we), .miso(miso)
);

// File: tb/test_spi_nor_pgm.sv
module test_spi_nor_pgm;
  localparam int AW    = 11;
  localparam int PROG  = 400;
  localparam int HALF  = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic [2:0] blk_prot = 3'd0;
  logic miso;

  always #2 clk = ~clk;

  spi_nor_pgm #(.ADDR_W(AW), .OFF_W(8), .PROG_CYCLES(PROG)) i_spi_nor_pgm (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .blk_prot(blk_prot), .miso(miso)
  );

  int checks = 0;
  int errors = 0;
  bit mode3 = 1'b0;
  bit wel_m = 1'b0;
  logic [7:0] mem_m  [DEPTH];
  logic [7:0] tx_buf [300];
  logic [7:0] rx_buf [256];

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    sck = 1'b0;
    mosi = b;
    wait_clk(HALF);
    r = miso;
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
  endtask

  task automatic frame_begin();
    sck = mode3;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic frame_end();
    wait_clk(HALF);
    if (!mode3) sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  function automatic bit prot_m(input int a);
    int pg = (a >> 8) & 7;
    return (blk_prot != 0) && (pg >= 8 - int'(blk_prot));
  endfunction

  function automatic void model_pp(input int a, input int len);
    logic [7:0] img [256];
    bit hit [256];
    int o = a & 255;
    int base = a & (DEPTH - 256);
    if (!wel_m || prot_m(a)) return;
    wel_m = 1'b0;
    for (int i = 0; i < 256; i++) hit[i] = 1'b0;
    for (int n = 0; n < len; n++) begin
      img[o] = tx_buf[n];
      hit[o] = 1'b1;
      o = (o + 1) & 255;
    end
    for (int i = 0; i < 256; i++)
      if (hit[i]) mem_m[base + i] = mem_m[base + i] & img[i];
  endfunction

  task automatic wren();
    logic [7:0] d;
    frame_begin(); xfer(8'h06, d); frame_end();
    wel_m = 1'b1;
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    frame_begin(); xfer(8'h05, d); xfer(8'h00, s); frame_end();
  endtask

  task automatic pp(input int a, input int len, input int extra);
    logic [7:0] d;
    logic r;
    frame_begin();
    xfer(8'h02, d);
    xfer(8'(a >> 16), d); xfer(8'(a >> 8), d); xfer(8'(a), d);
    for (int n = 0; n < len; n++) xfer(tx_buf[n], d);
    for (int k = 0; k < extra; k++) spi_bit(1'b1, r);
    frame_end();
    if (extra == 0 && len > 0) model_pp(a, len);
  endtask

  task automatic rd(input int a, input int len);
    logic [7:0] d;
    frame_begin();
    xfer(8'h03, d);
    xfer(8'(a >> 16), d); xfer(8'(a >> 8), d); xfer(8'(a), d);
    for (int n = 0; n < len; n++) xfer(8'h00, rx_buf[n]);
    frame_end();
  endtask

  task automatic verify(input int a, input int len, input string req);
    rd(a, len);
    for (int i = 0; i < len; i++) chk(req, rx_buf[i], mem_m[(a + i) % DEPTH]);
  endtask

  task automatic fill(input int len, input int seed);
    for (int n = 0; n < len; n++) tx_buf[n] = 8'(seed * 37 + n * 13 + (n >> 3));
  endtask

  task automatic wait_idle();
    wait_clk(PROG + 60);
  endtask

  initial begin
    logic [7:0] s;
    int a, len;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(5);

    // R1: idle output and reset status
    chk("R1 miso idle", miso, 0);
    rdsr(s);
    chk("R1 status after reset", s, 8'h00);

    // R3: program without write enable
    fill(4, 1);
    pp(12'h010, 4, 0);
    wait_idle();
    verify(12'h00E, 8, "R3");

    // R2: write enable sets the latch
    wren();
    rdsr(s);
    chk("R2 wel set", s, 8'h02);

    // R7: chip select off byte boundary, then no data byte
    fill(5, 2);
    pp(12'h300, 5, 3);
    rdsr(s);
    chk("R7 partial byte dropped", s, 8'h02);
    pp(12'h300, 0, 0);
    rdsr(s);
    chk("R7 no data dropped", s, 8'h02);
    verify(12'h300, 8, "R7");

    // R5 + R8: accepted program and busy window
    fill(5, 3);
    pp(12'h123, 5, 0);
    rdsr(s);
    chk("R8 busy, wel cleared", s, 8'h01);
    // R10: write enable while busy is ignored
    begin
      logic [7:0] d;
      frame_begin(); xfer(8'h06, d); frame_end();
    end
    rdsr(s);
    chk("R10 wel stays clear while busy", s, 8'h01);
    wait_idle();
    rdsr(s);
    chk("R8 busy done", s, 8'h00);
    verify(12'h118, 24, "R5");

    // R4: second program ANDs into the same bytes
    wren();
    fill(5, 9);
    pp(12'h123, 5, 0);
    wait_idle();
    verify(12'h123, 5, "R4");

    // R6: long burst wraps, last 256 kept
    wren();
    fill(300, 4);
    pp(12'h2F0, 300, 0);
    wait_idle();
    verify(12'h200, 256, "R6");

    // R9: protect level 2 covers pages 6 and 7
    blk_prot = 3'd2;
    wren();
    rdsr(s);
    chk("R9 status shows level", s, 8'h0A);
    fill(6, 5);
    pp(12'h700, 6, 0);
    wait_idle();
    rdsr(s);
    chk("R9 protected program dropped", s, 8'h0A);
    verify(12'h700, 8, "R9");
    pp(12'h540, 6, 0);
    wait_idle();
    verify(12'h540, 8, "R9");
    blk_prot = 3'd0;

    // R11: idle-high clock polarity
    mode3 = 1'b1;
    wren();
    rdsr(s);
    chk("R11 mode 3 status", s, 8'h02);
    fill(7, 6);
    pp(12'h040, 7, 0);
    wait_idle();
    verify(12'h03E, 10, "R11");
    mode3 = 1'b0;

    // R12: sequential read across a page and the top of the array
    verify(12'h1FE, 4, "R12");
    verify(12'h7FE, 4, "R12 wrap");

    // R5/R6 random programs
    for (int it = 0; it < 3; it++) begin
      a   = int'($urandom_range(0, 5)) * 256 + int'($urandom_range(0, 255));
      len = int'($urandom_range(1, 60));
      for (int n = 0; n < len; n++) tx_buf[n] = 8'($urandom);
      wren();
      pp(a, len, 0);
      wait_idle();
      verify(a & 12'h700, 256, "R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(190000);
    checks++;
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule